// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator Controller

The block gathers a parameterised number of external interrupt lines (up to 256) and reports them to a host through a three-level summary tree. Lines are grouped eight to a block and blocks eight to a master. Up to four masters roll up into one root byte. A single interrupt output is raised while any line is pending. Each input passes through a two-flop synchronizer. Each line can then be set to detect rising edges, falling edges or both. It can instead follow an active-high or active-low level.

The host reaches everything through a byte-wide synchronous register port. To configure a line, software first writes the block-select register. It then writes the configuration register, which carries the line's index within the selected block together with its trigger mode, mask and clear bits. To service an interrupt, software reads the root byte, then the master bytes, then the pending byte of each flagged block. The block-select register also picks which block's raw synchronized input levels appear in the live-level register.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset every line is in edge mode with both masks set and nothing pending, block select reads 0, every status byte reads 0 and `irq_o` is 0; input edges on a line in this state set nothing.
- R2: Register offsets: 0 root, 1..4 master 0..3 status, 5 block select (read/write, low 5 bits kept), 6 pending byte of the selected block, 7 configuration (write), 8 live input levels of the selected block.
- R3: Line n appears in the pending byte of block n/8 at bit n%8. Block b appears in master b/8 at bit b%8, and that bit is set exactly when the block has a pending line.
- R4: Master k appears at root bit k+1 and is set when any bit of that master is set. Root bits 0, 5, 6 and 7 read 0. `irq_o` is the OR of all master summaries.
- R5: A configuration write takes effect only when data bit 7 is 1. Bits 6:4 select the line within the selected block. Bit 0 = 1 selects level mode. Bit 1 masks the falling edge or low level. Bit 2 masks the rising edge or high level.
- R6: In edge mode, a synchronized rising edge sets the line's pending bit when bit 2 is clear, and a falling edge sets it when bit 1 is clear. The bit then stays set until a configuration write with bit 3 = 1 clears it.
- R7: In level mode the pending bit follows the active level: high when bit 2 is clear, low when bit 1 is clear. With both masks set the bit stays 0.
- R8: Bit 3 is a one-shot clear that is not kept in the configuration. A single write with bits 1, 2 and 3 set masks and acknowledges a line.
- R9: The live-level register returns the synchronized levels of all eight lines of the selected block, whatever their masks or pending state.
- R10: Lines with index at or above NUM_LINES read 0 in every status and live byte, and configuration writes to them have no effect.
- R11: Read data appears on `rdata_o` one clock after the read strobe. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | NUM_LINES | Asynchronous interrupt inputs |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one clock after `re_i` |
| irq_o | output | 1 | Summary interrupt to the host |

## Verification
The bench covers several mode changes. Switching a line from level to edge mode must freeze the last level result; a design that kept re-evaluating would drop or invent interrupts. A clear write must not stick, so a later edge must still latch. A design that stored bit 3 would leave the line permanently acknowledged. Further cases are writes with bit 7 low, writes aimed at lines past NUM_LINES, and lines in the partially used last block. Each of these must leave every status byte untouched. A design that decoded them would corrupt a neighbouring line's configuration or show phantom bits in the root, master or block bytes.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int MAX_MASTERS   = 4;
  localparam int BLKS_PER_MST  = 8;
  localparam int LINES_PER_BLK = 8;
  localparam int MAX_BLOCKS    = MAX_MASTERS * BLKS_PER_MST;
  localparam int MAX_LINES     = MAX_BLOCKS * LINES_PER_BLK;

  localparam logic [7:0] ADR_ROOT = 8'd0;
  localparam logic [7:0] ADR_MST0 = 8'd1;
  localparam logic [7:0] ADR_MST1 = 8'd2;
  localparam logic [7:0] ADR_MST2 = 8'd3;
  localparam logic [7:0] ADR_MST3 = 8'd4;
  localparam logic [7:0] ADR_BSEL = 8'd5;
  localparam logic [7:0] ADR_PEND = 8'd6;
  localparam logic [7:0] ADR_CFG  = 8'd7;
  localparam logic [7:0] ADR_LIVE = 8'd8;

  localparam int CB_LEVEL = 0;
  localparam int CB_MFALL = 1;
  localparam int CB_MRISE = 2;
  localparam int CB_CLR   = 3;
  localparam int CB_WEN   = 7;

  typedef struct packed {
    logic level;
    logic mask_rise;
    logic mask_fall;
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{level: 1'b0, mask_rise: 1'b1, mask_fall: 1'b1};
endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_tree_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      line_i,
  input  logic      cfg_we_i,
  input  line_cfg_t cfg_i,
  input  logic      clr_i,
  output logic      live_o,
  output logic      pend_o
);
  logic      sync1_q, sync2_q, prev_q;
  line_cfg_t cfg_q;
  logic      pend_q, pend_d;
  logic      rise, fall, evt, active, clr_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RESET;
    else if (cfg_we_i) cfg_q <= cfg_i;
  end

  assign rise    = sync2_q & ~prev_q;
  assign fall    = ~sync2_q & prev_q;
  assign evt     = (rise & ~cfg_q.mask_rise) | (fall & ~cfg_q.mask_fall);
  assign active  = (sync2_q & ~cfg_q.mask_rise) | (~sync2_q & ~cfg_q.mask_fall);
  assign clr_now = cfg_we_i & clr_i;

  // level mode tracks the input; edge mode latches until cleared, new event wins
  always_comb begin
    if (cfg_q.level) pend_d = active & ~clr_now;
    else             pend_d = evt | (pend_q & ~clr_now);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign live_o = sync2_q;
  assign pend_o = pend_q;

  // R6
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.level && pend_q && !clr_now) |=> pend_q);
  // R6
  edge_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.level && cfg_q.mask_rise && cfg_q.mask_fall && !pend_q) |=> !pend_q);
  // R7
  lvl_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.level && cfg_q.mask_rise && cfg_q.mask_fall) |=> !pend_q);
  // R5
  cfg_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_q));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_tree_pkg::*;
#(
  parameter int NUM_BLOCKS = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [MAX_LINES-1:0]        pend_all_i,
  output logic [MAX_BLOCKS-1:0]       mst_o,
  output logic [7:0]                  root_o,
  output logic                        irq_o
);
  logic [MAX_MASTERS-1:0] mst_any;

  for (genvar b = 0; b < MAX_BLOCKS; b++) begin : g_blk
    if (b < NUM_BLOCKS) begin : g_used
      assign mst_o[b] = |pend_all_i[b*LINES_PER_BLK +: LINES_PER_BLK];
    end else begin : g_unused
      assign mst_o[b] = 1'b0;
    end
  end

  for (genvar m = 0; m < MAX_MASTERS; m++) begin : g_mst
    assign mst_any[m] = |mst_o[m*BLKS_PER_MST +: BLKS_PER_MST];
  end

  assign root_o = {{(7 - MAX_MASTERS){1'b0}}, mst_any, 1'b0};
  assign irq_o  = |mst_any;

  // R3
  mst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_o != '0) |-> (pend_all_i != '0));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_tree_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   re_i,
  input  logic [7:0]             addr_i,
  input  logic [7:0]             wdata_i,
  input  logic [MAX_LINES-1:0]   pend_all_i,
  input  logic [MAX_LINES-1:0]   live_all_i,
  input  logic [MAX_BLOCKS-1:0]  mst_i,
  input  logic [7:0]             root_i,
  output logic [7:0]             rdata_o,
  output logic                   cfg_hit_o,
  output logic [7:0]             cfg_line_o,
  output line_cfg_t              cfg_o,
  output logic                   clr_o
);
  logic [4:0] blk_sel_q;
  logic [7:0] rd_mux, rdata_q, sel_pend, sel_live;
  logic [7:0] blk_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        blk_sel_q <= '0;
    else if (we_i && addr_i == ADR_BSEL) blk_sel_q <= wdata_i[4:0];
  end

  assign cfg_hit_o  = we_i && (addr_i == ADR_CFG) && wdata_i[CB_WEN];
  assign cfg_line_o = {blk_sel_q, wdata_i[6:4]};
  assign cfg_o      = '{level:     wdata_i[CB_LEVEL],
                        mask_rise: wdata_i[CB_MRISE],
                        mask_fall: wdata_i[CB_MFALL]};
  assign clr_o      = wdata_i[CB_CLR];

  assign blk_base = {blk_sel_q, 3'b000};
  assign sel_pend = pend_all_i[blk_base +: LINES_PER_BLK];
  assign sel_live = live_all_i[blk_base +: LINES_PER_BLK];

  always_comb begin
    case (addr_i)
      ADR_ROOT: rd_mux = root_i;
      ADR_MST0: rd_mux = mst_i[0*BLKS_PER_MST +: BLKS_PER_MST];
      ADR_MST1: rd_mux = mst_i[1*BLKS_PER_MST +: BLKS_PER_MST];
      ADR_MST2: rd_mux = mst_i[2*BLKS_PER_MST +: BLKS_PER_MST];
      ADR_MST3: rd_mux = mst_i[3*BLKS_PER_MST +: BLKS_PER_MST];
      ADR_BSEL: rd_mux = {3'b000, blk_sel_q};
      ADR_PEND: rd_mux = sel_pend;
      ADR_LIVE: rd_mux = sel_live;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R2
  bsel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADR_BSEL) |=> $stable(blk_sel_q));
  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int NUM_LINES = 92
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [7:0]           addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 irq_o
);
  localparam int NUM_BLOCKS = (NUM_LINES + LINES_PER_BLK - 1) / LINES_PER_BLK;

  logic [MAX_LINES-1:0]  pend_all, live_all;
  logic [MAX_BLOCKS-1:0] mst;
  logic [7:0]            root;
  logic                  cfg_hit, clr;
  logic [7:0]            cfg_line;
  line_cfg_t             cfg;

  irq_reg_port u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .re_i       (re_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pend_all_i (pend_all),
    .live_all_i (live_all),
    .mst_i      (mst),
    .root_i     (root),
    .rdata_o    (rdata_o),
    .cfg_hit_o  (cfg_hit),
    .cfg_line_o (cfg_line),
    .cfg_o      (cfg),
    .clr_o      (clr)
  );

  for (genvar i = 0; i < MAX_LINES; i++) begin : g_line
    if (i < NUM_LINES) begin : g_used
      irq_line_cell u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .line_i   (irq_lines_i[i]),
        .cfg_we_i (cfg_hit && (cfg_line == 8'(i))),
        .cfg_i    (cfg),
        .clr_i    (clr),
        .live_o   (live_all[i]),
        .pend_o   (pend_all[i])
      );
    end else begin : g_unused
      assign live_all[i] = 1'b0;
      assign pend_all[i] = 1'b0;
    end
  end

  irq_summary #(.NUM_BLOCKS(NUM_BLOCKS)) u_sum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_all_i (pend_all),
    .mst_o      (mst),
    .root_o     (root),
    .irq_o      (irq_o)
  );

  // R4
  irq_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|pend_all));
endmodule

// File: tb/irq_tree_ctrl_test.sv
`timescale 1ns/1ps
module irq_tree_ctrl_test;
  localparam int NL = 92;
  localparam int NB = (NL + 7) / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [7:0]    addr = '0, wdata = '0;
  logic [7:0]    rdata;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit m_lvl[256], m_mr[256], m_mf[256], m_pend[256];

  always #4 clk = ~clk;

  irq_tree_ctrl #(.NUM_LINES(NL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  function automatic bit act(bit s, bit mr, bit mf);
    return (s && !mr) || (!s && !mf);
  endfunction

  function automatic bit cur(int i);
    return (i < NL) ? bit'(lines[i]) : 1'b0;
  endfunction

  function automatic logic [7:0] exp_pend(int b);
    logic [7:0] v = '0;
    for (int k = 0; k < 8; k++) v[k] = (b*8+k < NL) ? m_pend[b*8+k] : 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] exp_live(int b);
    logic [7:0] v = '0;
    for (int k = 0; k < 8; k++) v[k] = cur(b*8+k);
    return v;
  endfunction

  function automatic logic [7:0] exp_mst(int m);
    logic [7:0] v = '0;
    for (int k = 0; k < 8; k++) v[k] = (m*8+k < NB) ? (exp_pend(m*8+k) != 0) : 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] exp_root();
    logic [7:0] v = '0;
    for (int m = 0; m < 4; m++) v[m+1] = (exp_mst(m) != 0);
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  // full write with model update; valid=0 means bit 7 low
  task automatic cfg_line(int n, bit valid, bit lvl, bit mr, bit mf, bit clr);
    logic [7:0] d;
    d = {valid, 3'(n % 8), clr, mr, mf, lvl};
    wr(8'd5, 8'(n / 8));
    wr(8'd7, d);
    if (valid && n < NL) begin
      if (m_lvl[n]) m_pend[n] = act(cur(n), m_mr[n], m_mf[n]) && !clr;
      else if (clr) m_pend[n] = 1'b0;
      m_lvl[n] = lvl; m_mr[n] = mr; m_mf[n] = mf;
      if (lvl) m_pend[n] = act(cur(n), mr, mf);
    end
  endtask

  task automatic set_lines(logic [NL-1:0] nv);
    logic [NL-1:0] ov;
    ov = lines;
    @(negedge clk); lines = nv;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NL; i++) begin
      if (m_lvl[i]) m_pend[i] = act(nv[i], m_mr[i], m_mf[i]);
      else if ((nv[i] && !ov[i] && !m_mr[i]) || (!nv[i] && ov[i] && !m_mf[i])) m_pend[i] = 1'b1;
    end
  endtask

  task automatic check_block(int b);
    logic [7:0] d;
    wr(8'd5, 8'(b));
    rd(8'd6, d); chk("R3 pending byte", d, exp_pend(b));
    rd(8'd8, d); chk("R9 live byte", d, exp_live(b));
  endtask

  task automatic check_tree();
    logic [7:0] d;
    rd(8'd0, d); chk("R4 root", d, exp_root());
    for (int m = 0; m < 4; m++) begin
      rd(8'(1 + m), d); chk("R3 master", d, exp_mst(m));
    end
    chk("R4 irq_o", {7'd0, irq}, {7'd0, exp_root() != 0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) begin
      m_lvl[i] = 0; m_mr[i] = 1; m_mf[i] = 1; m_pend[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'd5, d); chk("R1 block select", d, 8'h00);
    chk("R1 irq_o", {7'd0, irq}, 8'h00);
    check_block(0);
    check_tree();
    set_lines('1);
    set_lines('0);
    check_block(0);
    check_block(11);
    chk("R1 masked edges", {7'd0, irq}, 8'h00);

    // R6 rising edge on line 5, clear not stored (R8)
    cfg_line(5, 1, 0, 0, 1, 1);
    set_lines(NL'(1) << 5);
    check_block(0); check_tree();
    cfg_line(5, 1, 0, 0, 1, 0);
    check_block(0);
    rd(8'd6, d); chk("R6 latched until clear", d, 8'h20);
    cfg_line(5, 1, 0, 0, 1, 1);
    rd(8'd6, d); chk("R6 cleared", d, 8'h00);
    set_lines('0);
    set_lines(NL'(1) << 5);
    rd(8'd6, d); chk("R8 clear not stored", d, 8'h20);
    // R8 mask-ack in one write
    cfg_line(5, 1, 0, 1, 1, 1);
    rd(8'd6, d); chk("R8 mask-ack", d, 8'h00);
    chk("R8 irq_o low", {7'd0, irq}, 8'h00);
    set_lines('0);
    rd(8'd6, d); chk("R8 stays masked", d, 8'h00);

    // R7 level active-low on line 70 (block 8, master 1 bit 0)
    cfg_line(70, 1, 1, 1, 0, 0);
    check_block(8); check_tree();
    rd(8'd2, d); chk("R3 master1 bit", d, 8'h01);
    rd(8'd0, d); chk("R4 root bit 2", d, 8'h04);
    set_lines(NL'(1) << 70);
    check_block(8); check_tree();
    // R5 write without bit 7 ignored
    cfg_line(70, 0, 0, 1, 1, 1);
    set_lines('0);
    rd(8'd6, d); chk("R5 bit7 low ignored", d, 8'h40);
    // R10 unused line 95 in block 11
    cfg_line(95, 1, 1, 0, 1, 0);
    set_lines(NL'(1) << 91);
    check_block(11); check_tree();
    // R11 unmapped offsets
    rd(8'd9, d); chk("R11 unmapped 9", d, 8'h00);
    rd(8'd200, d); chk("R11 unmapped 200", d, 8'h00);

    for (int it = 0; it < 250; it++) begin
      int op;
      op = $urandom % 4;
      if (op == 0)
        cfg_line($urandom % 96, 1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      else if (op == 1)
        cfg_line($urandom % 96, 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      else
        set_lines(lines ^ NL'({$urandom & $urandom, $urandom & $urandom, $urandom & $urandom}));
      check_block($urandom % NB);
      check_tree();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule